// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

The block estimates the frequency of a selected clock. The edge counter runs in the domain of the measured clock. A prescaler first divides that clock by a programmable factor. The counter then counts the divided periods while a gate is open. The gate lasts a programmable number of reference-clock cycles. The reference clock is nominally 26 MHz, and it also clocks the register bus.

Software programs the block through two 32-bit words. The first word holds the run controls. The second holds the window length together with the raw result. A measurement follows this sequence:

1. Load the window length.
2. Pulse the active-low soft reset low, then high, with the enable bit set.
3. Write the start bit.
4. Poll the start bit until it drops to 0.
5. Read the count.

Software converts the count to kHz.

The measured clock comes from a multiplexer outside the block, which the `src_sel_o` output steers. The count is kept as a Gray code in the measured domain and reaches the reference domain through a two-flop synchronizer. It is latched into the result field only after a drain interval, so a read never returns a torn value.

Top module: `clk_freq_meter`

## Requirements
- R1: After hardware reset both words read 0 and `src_sel_o` is 0.
- R2: A write to word 0 (`reg_addr`=0) with bits 15, 12 and 4 all 1 starts a measurement. Bit 4 then reads 1 from the next cycle until the measurement ends, and afterwards reads 0 without any write.
- R3: A start write whose enable bit 12 is 0 is ignored, and bit 4 stays 0.
- R4: Word 1 bits [CNT_W-1:0] return the number of prescaled measured-clock periods that fell inside the gate window. The value lies within 2 counts of window time divided by (measured period × division).
- R5: Word 0 bits 31:24 hold a prescaler value p, which divides the measured clock by p+1. The value 3 gives divide-by-4.
- R6: Word 1 bits 25:16 hold the load count L. The gate stays open for L+1 reference cycles, and bit 4 reads 1 for exactly L+1+DRAIN_CYC cycles.
- R7: With no measured-clock edges the result is 0, and busy still clears after L+1+DRAIN_CYC cycles.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: Writing word 0 bit 15 to 0 aborts any measurement, so bit 4 reads 0 one cycle later. The result reads 0 while bit 15 is 0, and no start is accepted with bit 15 written 0.
- R10: With SEL_LAYOUT=1 the source select is word 0 bits 20:16. With SEL_LAYOUT=0 it is bits 2:0. Only that field drives `src_sel_o`.
- R11: A start write while busy is ignored and does not lengthen the measurement.
- R12: Word 1 bits 15:0 are read-only, so a write to word 1 changes only the load count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 1 | Word select: 0 = control, 1 = window/result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| src_sel_o | output | SEL_W | Select code for the external clock multiplexer |
| meas_clk | input | 1 | Clock being measured (multiplexer output) |

## Verification
The bench builds the block with CNT_W=10, SEL_LAYOUT=1 (5-bit select at 20:16), LOAD_W=10 and DRAIN_CYC=16. A 10-bit counter brings saturation within reach of a full 1024-cycle window, driven by a 7 ns clock at divide-by-1. The bench models the external multiplexer by mapping select codes to periods of 13 ns, 33 ns, 7 ns and a stopped clock. This lets a single select field exercise fast, slow, saturating and edge-free measurements. A short 16-cycle window exposes the exact busy length and the accuracy of the gate edges.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_START  = 4;
  localparam int BIT_EN     = 12;
  localparam int BIT_SOFT_N = 15;
  localparam int PRE_LSB    = 24;
  localparam int PRE_W      = 8;
  localparam int LOAD_LSB   = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GATE  = 2'b01,
    ST_DRAIN = 2'b10
  } fm_state_e;

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/fm_regs.sv
`timescale 1ns/1ps
module fm_regs import fm_pkg::*; #(
  parameter int SEL_LSB = 16,
  parameter int SEL_W   = 5,
  parameter int LOAD_W  = 10,
  parameter int CNT_W   = 16
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic                 busy_i,
  input  logic [CNT_W-1:0]     result_i,
  output logic                 soft_n_o,
  output logic [PRE_W-1:0]     pre_o,
  output logic [SEL_W-1:0]     sel_o,
  output logic [LOAD_W-1:0]    load_o,
  output logic                 start_req_o
);
  logic              soft_n_q, soft_n_d;
  logic              en_q, en_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [LOAD_W-1:0] load_q, load_d;
  logic              wr_ctl, wr_win;
  logic [REG_W-1:0]  word0, word1;
  logic              unused_wbits;

  assign wr_ctl = wr && !addr;
  assign wr_win = wr && addr;
  assign unused_wbits = ^wdata;

  always_comb begin
    soft_n_d = soft_n_q;
    en_d     = en_q;
    pre_d    = pre_q;
    sel_d    = sel_q;
    load_d   = load_q;
    if (wr_ctl) begin
      soft_n_d = wdata[BIT_SOFT_N];
      en_d     = wdata[BIT_EN];
      pre_d    = wdata[PRE_LSB +: PRE_W];
      sel_d    = wdata[SEL_LSB +: SEL_W];
    end
    if (wr_win) load_d = wdata[LOAD_LSB +: LOAD_W];
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      soft_n_q <= 1'b0;
      en_q     <= 1'b0;
      pre_q    <= '0;
      sel_q    <= '0;
      load_q   <= '0;
    end else begin
      soft_n_q <= soft_n_d;
      en_q     <= en_d;
      pre_q    <= pre_d;
      sel_q    <= sel_d;
      load_q   <= load_d;
    end
  end

  // a start needs enable and soft reset released in the same write
  assign start_req_o = wr_ctl && wdata[BIT_START] && wdata[BIT_EN] && wdata[BIT_SOFT_N];

  always_comb begin
    word0 = '0;
    word0[PRE_LSB +: PRE_W] = pre_q;
    word0[BIT_SOFT_N]       = soft_n_q;
    word0[BIT_EN]           = en_q;
    word0[BIT_START]        = busy_i;
    word0[SEL_LSB +: SEL_W] = sel_q;
    word1 = '0;
    word1[LOAD_LSB +: LOAD_W] = load_q;
    word1[CNT_W-1:0]          = result_i;
    rdata = addr ? word1 : word0;
  end

  assign soft_n_o = soft_n_q;
  assign pre_o    = pre_q;
  assign sel_o    = sel_q;
  assign load_o   = load_q;

  // R3: no start may be requested while enable is being written low
  assert_start_needs_en_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    start_req_o |=> en_q);
endmodule

// File: rtl/fm_edge_counter.sv
`timescale 1ns/1ps
module fm_edge_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             meas_clk,
  input  logic             arst_n,
  input  logic             gate_async,
  input  logic [PRE_W-1:0] pre_div,
  output logic [CNT_W-1:0] gray_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rs1_q, rs2_q;
  logic             mrst_n;
  logic             g1_q, g2_q;
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] gray_q, gray_d;
  logic             tick;

  // reset: asserted at once, released on the measured clock
  always_ff @(posedge meas_clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign mrst_n = rs2_q;

  always_ff @(posedge meas_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      g1_q <= 1'b0;
      g2_q <= 1'b0;
    end else begin
      g1_q <= gate_async;
      g2_q <= g1_q;
    end
  end

  assign tick = g2_q && (pcnt_q == pre_div);

  always_comb begin
    pcnt_d = pcnt_q;
    if (!g2_q || tick) pcnt_d = '0;
    else               pcnt_d = pcnt_q + 1'b1;
    cnt_d = cnt_q;
    if (tick && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    gray_d = cnt_q ^ (cnt_q >> 1);
  end

  always_ff @(posedge meas_clk or negedge mrst_n) begin
    if (!mrst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;

  assert_no_wrap_R8: assert property (@(posedge meas_clk) disable iff (!mrst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  assert_count_only_in_gate_R4: assert property (@(posedge meas_clk) disable iff (!mrst_n)
    !g2_q |=> $stable(cnt_q));
  assert_gray_one_bit_R4: assert property (@(posedge meas_clk) disable iff (!mrst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/fm_gate_ctrl.sv
`timescale 1ns/1ps
module fm_gate_ctrl import fm_pkg::*; #(
  parameter int LOAD_W    = 10,
  parameter int CNT_W     = 16,
  parameter int DRAIN_CYC = 16
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              soft_n,
  input  logic              start_req,
  input  logic [LOAD_W-1:0] load,
  input  logic [CNT_W-1:0]  gray_async,
  output logic              gate_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  result_o
);
  localparam int DR_W  = $clog2(DRAIN_CYC + 1);
  localparam int TMR_W = (LOAD_W > DR_W) ? LOAD_W : DR_W;
  localparam logic [TMR_W-1:0] DRAIN_LAST = TMR_W'(DRAIN_CYC - 1);

  fm_state_e        st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] gs1_q, gs2_q;
  logic [CNT_W-1:0] res_q, res_d;
  logic             gate_q, gate_d;
  logic             capture;
  logic             abort;

  assign abort = !soft_n && !start_req;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    capture = 1'b0;
    if (abort) begin
      st_d  = ST_IDLE;
      tmr_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_req) begin
          st_d  = ST_GATE;
          tmr_d = TMR_W'(load);
        end
        ST_GATE: if (tmr_q == '0) begin
          st_d  = ST_DRAIN;
          tmr_d = DRAIN_LAST;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
        ST_DRAIN: if (tmr_q == '0) begin
          st_d    = ST_IDLE;
          capture = 1'b1;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
    gate_d = (st_d == ST_GATE);
    res_d  = res_q;
    if (!soft_n)      res_d = '0;
    else if (capture) res_d = CNT_W'(gray_to_bin(32'(gs2_q)));
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      gate_q <= 1'b0;
      res_q  <= '0;
      gs1_q  <= '0;
      gs2_q  <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      gate_q <= gate_d;
      res_q  <= res_d;
      gs1_q  <= gray_async;
      gs2_q  <= gs1_q;
    end
  end

  assign gate_o   = gate_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign result_o = res_q;

  assert_soft_abort_R9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    abort |=> !busy_o);
  assert_gate_in_busy_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    gate_o |-> busy_o);
  assert_gate_closes_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (st_q == ST_GATE && tmr_q == '0) |=> !gate_o);
  assert_restart_ignored_R11: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (st_q == ST_GATE && tmr_q != '0 && soft_n) |=> (st_q == ST_GATE && tmr_q == $past(tmr_q) - 1'b1));
endmodule

// File: rtl/clk_freq_meter.sv
`timescale 1ns/1ps
module clk_freq_meter import fm_pkg::*; #(
  parameter int SEL_LAYOUT = 1,
  parameter int CNT_W      = 16,
  parameter int LOAD_W     = 10,
  parameter int DRAIN_CYC  = 16,
  localparam int SEL_W     = (SEL_LAYOUT == 1) ? 5 : 3
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [SEL_W-1:0] src_sel_o,
  input  logic             meas_clk
);
  localparam int SEL_LSB = (SEL_LAYOUT == 1) ? 16 : 0;

  logic              soft_n;
  logic [PRE_W-1:0]  pre;
  logic [LOAD_W-1:0] load;
  logic              start_req;
  logic              busy;
  logic              gate;
  logic [CNT_W-1:0]  result;
  logic [CNT_W-1:0]  gray_m;
  logic              arst_m_n;

  fm_regs #(.SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .LOAD_W(LOAD_W), .CNT_W(CNT_W)) u_regs (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .busy_i     (busy),
    .result_i   (result),
    .soft_n_o   (soft_n),
    .pre_o      (pre),
    .sel_o      (src_sel_o),
    .load_o     (load),
    .start_req_o(start_req)
  );

  fm_gate_ctrl #(.LOAD_W(LOAD_W), .CNT_W(CNT_W), .DRAIN_CYC(DRAIN_CYC)) u_ctrl (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .soft_n    (soft_n),
    .start_req (start_req),
    .load      (load),
    .gray_async(gray_m),
    .gate_o    (gate),
    .busy_o    (busy),
    .result_o  (result)
  );

  assign arst_m_n = rst_n & soft_n;

  fm_edge_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .meas_clk  (meas_clk),
    .arst_n    (arst_m_n),
    .gate_async(gate),
    .pre_div   (pre),
    .gray_o    (gray_m)
  );
endmodule

// File: tb/clk_freq_meter_tb_top.sv
`timescale 1ns/1ps
module clk_freq_meter_tb_top;
  localparam int CNT_W = 10;
  localparam int DRAIN = 16;
  localparam real TREF = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  src_sel;
  logic        meas_clk = 1'b0;
  real         meas_p;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  clk_freq_meter #(.SEL_LAYOUT(1), .CNT_W(CNT_W), .LOAD_W(10), .DRAIN_CYC(DRAIN)) dut_i (
    .clk_ref(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_sel_o(src_sel), .meas_clk(meas_clk)
  );

  always #(TREF/2.0) clk = ~clk;

  // model of the external clock multiplexer
  function automatic real period_of(input logic [4:0] s);
    case (s)
      5'd0:    return 13.0;
      5'd5:    return 33.0;
      5'd17:   return 7.0;
      default: return 0.0;
    endcase
  endfunction

  always begin
    meas_p = period_of(src_sel);
    if (meas_p == 0.0) begin
      meas_clk = 1'b0;
      #5;
    end else begin
      #(meas_p/2.0);
      meas_clk = ~meas_clk;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input real exp, input real tol);
    real d;
    checks++;
    d = real'(act) - exp;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %f", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl_word(input int s, input int p);
    return (32'(p) << 24) | (32'(s) << 16) | 32'h0000_1000;
  endfunction

  task automatic measure(input int s, input int p, input int ld, input bit extra_start,
                         output int res, output int cyc);
    logic [31:0] base, r;
    base = ctl_word(s, p);
    reg_write(1'b1, 32'(ld) << 16);
    reg_write(1'b0, base);
    reg_write(1'b0, base | 32'h8000);
    repeat (6) @(negedge clk);
    reg_write(1'b0, base | 32'h8010);
    cyc = 0;
    reg_read(1'b0, r);
    while (r[4] && cyc < 5000) begin
      cyc++;
      if (extra_start && cyc == 5) begin
        reg_wr = 1'b1; reg_wdata = base | 32'h8010;
      end else begin
        reg_wr = 1'b0;
      end
      @(negedge clk);
      reg_read(1'b0, r);
    end
    reg_wr = 1'b0;
    chk("R2", "start bit self-clears", int'(r[4]), 0);
    reg_read(1'b1, r);
    res = int'(r[15:0]);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    reg_read(1'b0, r); chk("R1", "word0 after reset", int'(r), 0);
    reg_read(1'b1, r); chk("R1", "word1 after reset", int'(r), 0);
    chk("R1", "src_sel after reset", int'(src_sel), 0);
  endtask

  task automatic t_select;
    reg_write(1'b0, (32'd17 << 16) | 32'h7);
    chk("R10", "select field drives output", int'(src_sel), 17);
    reg_write(1'b0, 32'h7);
    chk("R10", "low bits do not select", int'(src_sel), 0);
  endtask

  task automatic t_no_enable;
    logic [31:0] r;
    reg_write(1'b0, 32'h8000);
    reg_write(1'b0, 32'h8010);
    reg_read(1'b0, r); chk("R3", "start without enable", int'(r[4]), 0);
    @(negedge clk);
    reg_read(1'b0, r); chk("R3", "still idle", int'(r[4]), 0);
  endtask

  task automatic t_basic;
    int res, cyc;
    measure(0, 3, 1023, 1'b0, res, cyc);
    chk("R6", "busy length full window", cyc, 1024 + DRAIN);
    chk_near("R4", "13ns div4 count", res, 1024.0*TREF/(13.0*4.0), 2.0);
    measure(0, 7, 1023, 1'b0, res, cyc);
    chk_near("R5", "13ns div8 count", res, 1024.0*TREF/(13.0*8.0), 2.0);
    measure(5, 0, 1023, 1'b0, res, cyc);
    chk_near("R5", "33ns div1 count", res, 1024.0*TREF/33.0, 2.0);
  endtask

  task automatic t_short;
    int res, cyc;
    measure(5, 3, 15, 1'b0, res, cyc);
    chk("R6", "busy length short window", cyc, 16 + DRAIN);
    chk_near("R4", "short window count", res, 16.0*TREF/(33.0*4.0), 2.0);
    measure(5, 3, 15, 1'b1, res, cyc);
    chk("R11", "restart while busy ignored", cyc, 16 + DRAIN);
  endtask

  task automatic t_saturate;
    int res, cyc;
    logic [31:0] r;
    measure(17, 0, 1023, 1'b0, res, cyc);
    chk("R8", "count saturates", res, (1 << CNT_W) - 1);
    reg_write(1'b1, (32'h155 << 16));
    reg_read(1'b1, r);
    chk("R12", "load reads back", int'(r[25:16]), 'h155);
    chk("R12", "result not writable", int'(r[15:0]), (1 << CNT_W) - 1);
  endtask

  task automatic t_stopped;
    int res, cyc;
    measure(31, 3, 1023, 1'b0, res, cyc);
    chk("R7", "no edges gives zero", res, 0);
    chk("R7", "busy still clears on time", cyc, 1024 + DRAIN);
  endtask

  task automatic t_abort;
    logic [31:0] base, r;
    base = ctl_word(0, 3);
    reg_write(1'b1, 32'h3FF << 16);
    reg_write(1'b0, base);
    reg_write(1'b0, base | 32'h8000);
    reg_write(1'b0, base | 32'h8010);
    repeat (10) @(negedge clk);
    reg_read(1'b0, r); chk("R9", "busy before abort", int'(r[4]), 1);
    reg_write(1'b0, base);
    @(negedge clk);
    reg_read(1'b0, r); chk("R9", "busy after abort", int'(r[4]), 0);
    reg_read(1'b1, r); chk("R9", "result during soft reset", int'(r[15:0]), 0);
    reg_write(1'b0, base | 32'h0010);
    @(negedge clk);
    reg_read(1'b0, r); chk("R9", "start refused in soft reset", int'(r[4]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_no_enable();
    t_basic();
    t_short();
    t_saturate();
    t_stopped();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule